// File: doc/BRIEF.md
# Stereo DC Offset Trim with Estimate Hold

This block sits on the sample stream that leaves a decimation filter. It removes the DC component from each channel of a two-channel stream. For every valid sample it subtracts that channel's running DC estimate and sends out the corrected value one clock later, with the channel tag attached. The same sample then updates the estimate through a leaky integrator whose time constant is set by a right shift. The estimate carries fractional bits, so offsets smaller than one LSB still build up.

A hold input stops every estimate from changing but keeps subtracting the held values. This turns the tracking filter into a fixed-offset trim stage, which a system uses for calibration. First run with tracking enabled until the estimates settle. Then assert hold. From that point the block cancels any offset that is present upstream. When tracking and hold are both low, samples pass through untouched and the estimate of each sample's channel is cleared.

Top module: `dc_trim`

## Requirements
- R1: After reset, outValid and outData are 0 and every channel's estimate is zero, so the first tracked sample is output unchanged.
- R2: outValid is high exactly one clock after a cycle with inValid high, and low one clock after a cycle with inValid low.
- R3: outCh equals the inCh of the sample that produced the output.
- R4: With filtEn=0 and freezeEn=0, outData equals inData, and the estimate of that sample's channel is set to zero.
- R5: With filtEn=1 and freezeEn=0, the output is sat(x − floor(A/4096)), where A is the channel's estimate scaled by 2^12 as it stood before this sample. After the output is formed, A becomes A + floor((x·4096 − A)/4096). This is a shift of 12 for both the fraction and the time constant.
- R6: A sample on one channel leaves the other channel's estimate unchanged.
- R7: With freezeEn=1, whatever filtEn is, the estimate is held and is still subtracted: outData = sat(x − floor(A/4096)).
- R8: When freezeEn drops, tracking resumes from the held estimate, not from zero.
- R9: The subtraction saturates to the range −8388608 to 8388607 and never wraps.
- R10: Cycles with inValid low change no estimate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input sample strobe |
| inCh | input | 1 | Input channel tag (0 or 1) |
| inData | input | 24 | Signed input sample |
| filtEn | input | 1 | Enable estimate tracking and removal |
| freezeEn | input | 1 | Hold estimates and keep removing them |
| outValid | output | 1 | Output sample strobe |
| outCh | output | 1 | Channel tag of the output sample |
| outData | output | 24 | Signed corrected sample |

## Verification
The hardest case to reach from the ports is saturation. Saturation needs an estimate near full scale with a sample of the opposite extreme, and with a shift of 12 an estimate only gets there after many thousands of samples. The stimulus therefore feeds one channel a full-scale value without a break for 20000 cycles, freezes the estimate, and then applies the opposite extreme. The second channel gets the mirror image of this. The calibration flow is covered the same way: a long DC run, then a freeze, a sample on the other channel, and a release.

// File: rtl/dc_trim_pkg.sv
package dc_trim_pkg;
  // Strobes from control to datapath for the sample present this cycle
  typedef struct packed {
    logic take;    // a sample is present
    logic clear;   // zero the addressed estimate
    logic track;   // update the addressed estimate
    logic remove;  // subtract the estimate from the sample
  } trimStrobe_t;
endpackage

// File: rtl/dc_trim_ctrl.sv
module dc_trim_ctrl
  import dc_trim_pkg::*;
(
  input  logic        inValid,
  input  logic        filtEn,
  input  logic        freezeEn,
  output trimStrobe_t stb
);
  // Hold has priority over tracking; bypass only when both are low
  always_comb begin
    stb.take   = inValid;
    stb.clear  = inValid && !filtEn && !freezeEn;
    stb.track  = inValid && filtEn && !freezeEn;
    stb.remove = filtEn || freezeEn;
  end
endmodule

// File: rtl/dc_trim_dp.sv
module dc_trim_dp
  import dc_trim_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int FRAC_W = 12,
  parameter int SHIFT  = 12,
  parameter int NUM_CH = 2
) (
  input  logic                                     clk,
  input  logic                                     rstN,
  input  trimStrobe_t                              stb,
  input  logic [$clog2(NUM_CH)-1:0]                inCh,
  input  logic signed [DATA_W-1:0]                 inData,
  output logic                                     outValid,
  output logic [$clog2(NUM_CH)-1:0]                outCh,
  output logic signed [DATA_W-1:0]                 outData,
  output logic [NUM_CH-1:0][DATA_W+FRAC_W-1:0]     estAll
);
  localparam int CH_W  = $clog2(NUM_CH);
  localparam int ACC_W = DATA_W + FRAC_W;

  logic signed [ACC_W-1:0]  accQ [NUM_CH];
  logic signed [ACC_W-1:0]  accSel, accNext;
  logic signed [ACC_W:0]    xScaled, accWide, errW, stepW;
  logic signed [DATA_W-1:0] estSel, satVal, result;
  logic signed [DATA_W:0]   subW;

  always_comb begin
    accSel  = accQ[inCh];
    estSel  = DATA_W'(accSel >>> FRAC_W);
    // leaky integrator step on the scaled estimate
    xScaled = {inData[DATA_W-1], inData, {FRAC_W{1'b0}}};
    accWide = {accSel[ACC_W-1], accSel};
    errW    = xScaled - accWide;
    stepW   = errW >>> SHIFT;
    accNext = ACC_W'(accWide + stepW);
    // saturating removal
    subW    = {inData[DATA_W-1], inData} - {estSel[DATA_W-1], estSel};
    if (subW[DATA_W] != subW[DATA_W-1])
      satVal = subW[DATA_W] ? {1'b1, {(DATA_W-1){1'b0}}} : {1'b0, {(DATA_W-1){1'b1}}};
    else
      satVal = subW[DATA_W-1:0];
    result  = stb.remove ? satVal : inData;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        accQ[c] <= '0;
      else if (inCh == CH_W'(c)) begin
        if (stb.clear)
          accQ[c] <= '0;
        else if (stb.track)
          accQ[c] <= accNext;
      end
    end
    assign estAll[c] = accQ[c];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outCh    <= '0;
      outData  <= '0;
    end else begin
      outValid <= stb.take;
      if (stb.take) begin
        outCh   <= inCh;
        outData <= result;
      end
    end
  end
endmodule

// File: rtl/dc_trim.sv
module dc_trim
  import dc_trim_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int FRAC_W = 12,
  parameter int SHIFT  = 12,
  parameter int NUM_CH = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  input  logic [$clog2(NUM_CH)-1:0]   inCh,
  input  logic signed [DATA_W-1:0]    inData,
  input  logic                        filtEn,
  input  logic                        freezeEn,
  output logic                        outValid,
  output logic [$clog2(NUM_CH)-1:0]   outCh,
  output logic signed [DATA_W-1:0]    outData
);
  trimStrobe_t stb;
  logic [NUM_CH-1:0][DATA_W+FRAC_W-1:0] estAll;

  dc_trim_ctrl u_ctrl (
    .inValid (inValid),
    .filtEn  (filtEn),
    .freezeEn(freezeEn),
    .stb     (stb)
  );

  dc_trim_dp #(
    .DATA_W(DATA_W), .FRAC_W(FRAC_W), .SHIFT(SHIFT), .NUM_CH(NUM_CH)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .inCh    (inCh),
    .inData  (inData),
    .outValid(outValid),
    .outCh   (outCh),
    .outData (outData),
    .estAll  (estAll)
  );
endmodule

// File: rtl/dc_trim_chk.sv
module dc_trim_chk #(
  parameter int DATA_W = 24,
  parameter int FRAC_W = 12,
  parameter int NUM_CH = 2
) (
  input logic                                 clk,
  input logic                                 rstN,
  input logic                                 inValid,
  input logic [$clog2(NUM_CH)-1:0]            inCh,
  input logic [DATA_W-1:0]                    inData,
  input logic                                 filtEn,
  input logic                                 freezeEn,
  input logic                                 outValid,
  input logic [$clog2(NUM_CH)-1:0]            outCh,
  input logic [DATA_W-1:0]                    outData,
  input logic [NUM_CH-1:0][DATA_W+FRAC_W-1:0] estAll
);
  localparam int CH_W = $clog2(NUM_CH);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R2
  AST_TAG_CARRIED: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outCh == $past(inCh)); // R3
  AST_BYPASS_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !filtEn && !freezeEn) |=> outData == $past(inData)); // R4
  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    freezeEn |=> $stable(estAll)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(estAll)); // R10

  for (genvar c = 0; c < NUM_CH; c++) begin : g_iso
    AST_OTHER_CH_STABLE: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && inCh != CH_W'(c)) |=> $stable(estAll[c])); // R6
  end
endmodule

bind dc_trim dc_trim_chk #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inCh(inCh), .inData(inData),
  .filtEn(filtEn), .freezeEn(freezeEn), .outValid(outValid), .outCh(outCh),
  .outData(outData), .estAll(estAll)
);

// File: tb/dc_trim_bench.sv
`timescale 1ns/1ps
module dc_trim_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [0:0] inCh = '0;
  logic signed [23:0] inData = '0;
  logic filtEn = 1'b0;
  logic freezeEn = 1'b0;
  logic outValid;
  logic [0:0] outCh;
  logic signed [23:0] outData;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  longint accM [2] = '{0, 0};

  always #2 clk = ~clk;  // 250 MHz

  dc_trim u_dc_trim (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inCh(inCh), .inData(inData),
    .filtEn(filtEn), .freezeEn(freezeEn), .outValid(outValid), .outCh(outCh),
    .outData(outData)
  );

  typedef struct packed {
    logic        ch;
    logic [23:0] data;
    logic        en;
    logic        frz;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{1'b0,  24'd100000,   1'b1, 1'b0},
    '{1'b1, -24'sd40000,   1'b1, 1'b0},
    '{1'b0,  24'd100000,   1'b1, 1'b0},
    '{1'b0,  24'd2000000,  1'b1, 1'b0},
    '{1'b1, -24'sd40000,   1'b1, 1'b0},
    '{1'b0,  24'd5,        1'b1, 1'b1},
    '{1'b1,  24'd7,        1'b0, 1'b1},
    '{1'b0, -24'sd300,     1'b1, 1'b1},
    '{1'b0,  24'd777,      1'b1, 1'b0},
    '{1'b1,  24'd12345,    1'b0, 1'b0},
    '{1'b1,  24'd500,      1'b1, 1'b0},
    '{1'b0, -24'sd8388608, 1'b1, 1'b0},
    '{1'b0,  24'd8388607,  1'b1, 1'b0},
    '{1'b0,  24'd42,       1'b0, 1'b0},
    '{1'b0,  24'd42,       1'b1, 1'b0},
    '{1'b1, -24'sd1,       1'b1, 1'b0}
  };

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one sample, update the reference model, optionally check the output
  task automatic send(input int ch, input longint x, input bit en, input bit frz,
                      input string tag, input bit doCheck);
    longint est, y;
    @(negedge clk);
    inValid = 1'b1; inCh = 1'(ch); inData = 24'(x); filtEn = en; freezeEn = frz;
    est = accM[ch] >>> 12;
    if (!en && !frz) begin
      y = x; accM[ch] = 0;
    end else begin
      y = x - est;
      if (y > 8388607) y = 8388607;
      if (y < -8388608) y = -8388608;
      if (!frz) accM[ch] = accM[ch] + (((x <<< 12) - accM[ch]) >>> 12);
    end
    @(posedge clk); #1;
    if (doCheck) begin
      chk({tag, " data"}, longint'(outData), y);
      chk("R2 valid", longint'(outValid), 1);
      chk("R3 channel", longint'(outCh), longint'(ch));
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    inValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 outValid", longint'(outValid), 0);
    chk("R1 outData", longint'(outData), 0);
    @(negedge clk);
    rstN = 1'b1;
    // R1: zero estimate -> first tracked sample unchanged
    send(0, 1000, 1'b1, 1'b0, "R1", 1'b1);
    chk("R1 first", longint'(outData), 1000);

    // table walk: R4 bypass, R5 tracking, R7 hold
    foreach (VECS[i]) begin
      string t;
      t = VECS[i].frz ? "R7" : (VECS[i].en ? "R5" : "R4");
      send(int'(VECS[i].ch), longint'($signed(VECS[i].data)), VECS[i].en, VECS[i].frz, t, 1'b1);
    end

    // R2 / R10: idle cycles produce nothing and change no estimate
    idle(5);
    chk("R2 idle", longint'(outValid), 0);
    send(0, 3000, 1'b1, 1'b0, "R10", 1'b1);

    // calibration: settle on DC, freeze, check residual
    for (int k = 0; k < 30000; k++) send(0, 50000, 1'b1, 1'b0, "R5", 1'b0);
    send(0, 50000, 1'b1, 1'b1, "R7", 1'b1);
    checks++;
    if (outData > 200 || outData < -200) begin
      failures++;
      $display("FAIL R7 residual actual=%0d expected=|x|<=200", outData);
    end
    send(1, 0, 1'b1, 1'b0, "R6", 1'b1);  // other channel untouched by ch0 run
    send(0, 50000, 1'b0, 1'b1, "R7", 1'b1);
    send(0, 50000, 1'b1, 1'b0, "R8", 1'b1);  // resumes from held estimate
    send(0, 50000, 1'b1, 1'b0, "R8", 1'b1);

    // R9: positive saturation on ch0
    for (int k = 0; k < 20000; k++) send(0, -8388608, 1'b1, 1'b0, "R9", 1'b0);
    send(0, 8388607, 1'b1, 1'b1, "R9", 1'b1);
    chk("R9 max", longint'(outData), 8388607);
    // R9: negative saturation on ch1
    for (int k = 0; k < 20000; k++) send(1, 8388607, 1'b1, 1'b0, "R9", 1'b0);
    send(1, -8388608, 1'b1, 1'b1, "R9", 1'b1);
    chk("R9 min", longint'(outData), -8388608);
    // R4: bypass clears the estimate, next tracked sample unchanged
    send(1, 1234, 1'b0, 1'b0, "R4", 1'b1);
    send(1, 1234, 1'b1, 1'b0, "R4", 1'b1);
    chk("R4 cleared", longint'(outData), 1234);

    idle(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule